// File: doc/BRIEF.md
# Unaligned Access Byte Sequencer

The block takes one halfword, word or doubleword access at an arbitrary byte address and carries it out as a series of single-byte transactions on a narrow request/ready bus. It visits the bytes in ascending address order, one at a time. For loads it places each returned byte into the result according to the selected byte order. For stores it picks the outgoing byte from the store data according to the same order. A doubleword access is two complete word accesses, at the base address and at the base address plus four.

A request is offered with `req_valid` while the block is idle. It carries the address, a size code, the direction, up to two store words, a big-endian select, a sign-extend flag for halfword loads and an unprivileged attribute. The attribute is copied onto every byte transaction. The block reports the end of the access with a one-cycle `done` pulse, or with a `fault` pulse if any byte transaction returned a bus error. On a fault the block stops issuing bytes at once and leaves the load results as they were.

Top module: `unaligned_byte_seq`

## Requirements
- R1: After reset `busy`, `done`, `fault` and `bus_req` are low, and `rdata0` and `rdata1` read zero.
- R2: The size code selects the number of byte transactions: 2'b00 halfword (2 bytes), 2'b10 doubleword (8 bytes), 2'b01 or 2'b11 word (4 bytes). Transaction k of an access goes to address base+k, so the bytes are visited in strictly ascending order, one per handshake.
- R3: In little-endian mode (`req_big_endian`=0), the byte at base+k of a word load lands in bits 8k+7:8k of the result.
- R4: In big-endian mode, the byte at base+k of a word load lands in bits 31-8k:24-8k. In a halfword load the first byte lands in bits 15:8 and the second in bits 7:0.
- R5: A halfword load returns bit 15 copied into bits 31:16 when `req_sign_ext` is 1, and zeros there when it is 0. The flag has no effect on word loads. A load other than a doubleword load returns zero in `rdata1`.
- R6: A store sends the byte for bits 7:0 first in little-endian mode. In big-endian mode it sends the most significant byte of the access first (bits 31:24 for a word, bits 15:8 for a halfword). Each following transaction sends the next byte in that order.
- R7: A doubleword load returns the word built from base..base+3 in `rdata0` and the word built from base+4..base+7 in `rdata1`. A doubleword store sends `req_wdata0` to base..base+3 and `req_wdata1` to base+4..base+7.
- R8: A bus error on any byte ends the access. No further byte is issued, `fault` pulses for one cycle instead of `done`, and `rdata0` and `rdata1` keep their previous values.
- R9: `busy` rises in the cycle after a request is taken and stays high up to and including the `done` or `fault` cycle, then falls. A request offered while `busy` is high is ignored.
- R10: `bus_unpriv` carries the request's unprivileged attribute on every byte transaction of that access.
- R11: While `bus_req` is high and `bus_ready` is low, `bus_addr`, `bus_write` and `bus_wdata` hold their values.
- R12: Byte addresses wrap modulo 2^ADDR_W when an access crosses the top of the address space.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered (taken when idle) |
| req_addr | input | ADDR_W | Byte address of the access |
| req_size | input | 2 | Size code: 00 half, 01/11 word, 10 doubleword |
| req_write | input | 1 | 1 = store, 0 = load |
| req_wdata0 | input | 32 | Store data, first word |
| req_wdata1 | input | 32 | Store data, second word of a doubleword |
| req_big_endian | input | 1 | Byte order select, 1 = big-endian |
| req_sign_ext | input | 1 | Sign-extend a halfword load |
| req_unpriv | input | 1 | Unprivileged attribute for the bus |
| busy | output | 1 | Access in progress |
| done | output | 1 | One-cycle pulse: access completed without error |
| fault | output | 1 | One-cycle pulse: access ended on a bus error |
| rdata0 | output | 32 | Load result, first word |
| rdata1 | output | 32 | Load result, second word |
| bus_req | output | 1 | Byte transaction request |
| bus_addr | output | ADDR_W | Byte transaction address |
| bus_write | output | 1 | Byte transaction direction |
| bus_wdata | output | 8 | Byte store data |
| bus_unpriv | output | 1 | Unprivileged attribute of the transaction |
| bus_ready | input | 1 | Transaction completes this cycle |
| bus_rdata | input | 8 | Byte read data, valid with bus_ready |
| bus_err | input | 1 | Transaction error, valid with bus_ready |

## Verification
The bench builds the block with ADDR_W set to 12 instead of the default 32. This puts the top of the address space within reach, so a word access at 0xFFE visibly wraps to 0x000 and 0x001. The bench's 64-byte memory model still covers both ends of that crossing. The narrower address also keeps the logged bus addresses short enough to compare whole sequences. Wait states can be switched on in the bus model, which holds a transaction for two extra cycles and so exercises the stability rule.

// File: rtl/ubs_pkg.sv
package ubs_pkg;
  localparam int BYTE_W     = 8;
  localparam int WORD_BYTES = 4;
  localparam int WORD_W     = BYTE_W * WORD_BYTES;
  localparam int NUM_WORDS  = 2;
  localparam int IDX_W      = $clog2(WORD_BYTES * NUM_WORDS);
  localparam int LANE_W     = $clog2(WORD_BYTES);

  localparam logic [1:0] SZ_HALF  = 2'b00;
  localparam logic [1:0] SZ_DWORD = 2'b10;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_XFER = 2'd1,
    ST_FIN  = 2'd2
  } seq_state_e;

  typedef struct packed {
    logic [1:0] size;
    logic       write;
    logic       big_end;
    logic       sign_ext;
    logic       unpriv;
  } req_attr_t;

  function automatic logic [IDX_W:0] beats_for(input logic [1:0] sz);
    case (sz)
      SZ_HALF:  return (IDX_W+1)'(2);
      SZ_DWORD: return (IDX_W+1)'(WORD_BYTES * NUM_WORDS);
      default:  return (IDX_W+1)'(WORD_BYTES);
    endcase
  endfunction
endpackage

// File: rtl/ubs_ctrl.sv
module ubs_ctrl
  import ubs_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  req_attr_t         req_attr,
  input  logic              bus_ready,
  input  logic              bus_err,
  output seq_state_e        state,
  output logic [IDX_W-1:0]  idx,
  output logic [ADDR_W-1:0] base,
  output req_attr_t         attr,
  output logic              err_seen,
  output logic              accept,
  output logic              beat,
  output logic              last
);
  seq_state_e        state_q, state_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic [ADDR_W-1:0] base_q;
  req_attr_t         attr_q;
  logic              err_q, err_d;

  assign accept = (state_q == ST_IDLE) && req_valid;
  assign beat   = (state_q == ST_XFER) && bus_ready;
  assign last   = ((IDX_W+1)'(idx_q) + (IDX_W+1)'(1)) == beats_for(attr_q.size);

  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    err_d   = err_q;
    unique case (state_q)
      ST_IDLE: begin
        if (req_valid) begin
          state_d = ST_XFER;
          idx_d   = '0;
          err_d   = 1'b0;
        end
      end
      ST_XFER: begin
        if (bus_ready) begin
          if (bus_err) begin
            err_d   = 1'b1;
            state_d = ST_FIN;
          end else if (last) begin
            state_d = ST_FIN;
          end else begin
            idx_d = idx_q + 1'b1;
          end
        end
      end
      ST_FIN:  state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
      err_q   <= err_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      attr_q <= '0;
    end else if (accept) begin
      base_q <= req_addr;
      attr_q <= req_attr;
    end
  end

  assign state    = state_q;
  assign idx      = idx_q;
  assign base     = base_q;
  assign attr     = attr_q;
  assign err_seen = err_q;
endmodule

// File: rtl/ubs_lane_map.sv
module ubs_lane_map
  import ubs_pkg::*;
(
  input  logic [IDX_W-1:0]  idx,
  input  logic              half,
  input  logic              big_end,
  output logic [LANE_W-1:0] lane,
  output logic              word_sel
);
  logic [LANE_W-1:0] pos;

  assign pos      = idx[LANE_W-1:0];
  assign word_sel = idx[IDX_W-1];

  always_comb begin
    if (!big_end)
      lane = pos;
    else if (half)
      lane = LANE_W'(1) - pos;
    else
      lane = LANE_W'(WORD_BYTES - 1) - pos;
  end
endmodule

// File: rtl/ubs_load_asm.sv
module ubs_load_asm
  import ubs_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              take,
  input  logic              commit,
  input  logic              word_sel,
  input  logic [LANE_W-1:0] lane,
  input  logic [BYTE_W-1:0] byte_in,
  input  logic              half,
  input  logic              sign_ext,
  output logic [WORD_W-1:0] res0,
  output logic [WORD_W-1:0] res1
);
  localparam int HALF_W = WORD_W / 2;

  logic [NUM_WORDS-1:0][WORD_W-1:0] stage_q, stage_d;
  logic [NUM_WORDS-1:0][WORD_W-1:0] res_q, res_d;
  logic                             ext_bit;

  always_comb begin
    stage_d = stage_q;
    if (clr)
      stage_d = '0;
    else if (take)
      stage_d[word_sel][int'(lane)*BYTE_W +: BYTE_W] = byte_in;
  end

  assign ext_bit = half && sign_ext && stage_d[0][HALF_W-1];

  always_comb begin
    res_d = res_q;
    if (commit) begin
      res_d[0] = half ? {{HALF_W{ext_bit}}, stage_d[0][HALF_W-1:0]} : stage_d[0];
      res_d[1] = stage_d[1];
    end
  end

  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        stage_q[w] <= '0;
      else if (clr || take)
        stage_q[w] <= stage_d[w];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        res_q[w] <= '0;
      else if (commit)
        res_q[w] <= res_d[w];
    end
  end

  assign res0 = res_q[0];
  assign res1 = res_q[1];
endmodule

// File: rtl/ubs_store_sel.sv
module ubs_store_sel
  import ubs_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_en,
  input  logic [WORD_W-1:0] wdata0,
  input  logic [WORD_W-1:0] wdata1,
  input  logic              write,
  input  logic              word_sel,
  input  logic [LANE_W-1:0] lane,
  output logic [BYTE_W-1:0] byte_out
);
  logic [NUM_WORDS-1:0][WORD_W-1:0] wd_q;
  logic [NUM_WORDS-1:0][WORD_W-1:0] wd_in;

  assign wd_in[0] = wdata0;
  assign wd_in[1] = wdata1;

  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_hold
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        wd_q[w] <= '0;
      else if (load_en)
        wd_q[w] <= wd_in[w];
    end
  end

  always_comb begin
    byte_out = '0;
    if (write)
      byte_out = wd_q[word_sel][int'(lane)*BYTE_W +: BYTE_W];
  end
endmodule

// File: rtl/unaligned_byte_seq.sv
module unaligned_byte_seq
  import ubs_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_size,
  input  logic              req_write,
  input  logic [31:0]       req_wdata0,
  input  logic [31:0]       req_wdata1,
  input  logic              req_big_endian,
  input  logic              req_sign_ext,
  input  logic              req_unpriv,
  output logic              busy,
  output logic              done,
  output logic              fault,
  output logic [31:0]       rdata0,
  output logic [31:0]       rdata1,
  output logic              bus_req,
  output logic [ADDR_W-1:0] bus_addr,
  output logic              bus_write,
  output logic [7:0]        bus_wdata,
  output logic              bus_unpriv,
  input  logic              bus_ready,
  input  logic [7:0]        bus_rdata,
  input  logic              bus_err
);
  seq_state_e        state;
  logic [IDX_W-1:0]  idx;
  logic [ADDR_W-1:0] base;
  req_attr_t         attr_in, attr;
  logic              err_seen, accept, beat, last;
  logic [LANE_W-1:0] lane;
  logic              word_sel, half, good_beat, load_take;

  assign attr_in = '{size: req_size, write: req_write, big_end: req_big_endian,
                     sign_ext: req_sign_ext, unpriv: req_unpriv};

  ubs_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_attr(attr_in), .bus_ready(bus_ready), .bus_err(bus_err),
    .state(state), .idx(idx), .base(base), .attr(attr), .err_seen(err_seen),
    .accept(accept), .beat(beat), .last(last)
  );

  assign half = (attr.size == SZ_HALF);

  ubs_lane_map u_map (
    .idx(idx), .half(half), .big_end(attr.big_end),
    .lane(lane), .word_sel(word_sel)
  );

  assign good_beat = beat && !bus_err;
  assign load_take = good_beat && !attr.write;

  ubs_load_asm u_load (
    .clk(clk), .rst_n(rst_n), .clr(accept), .take(load_take),
    .commit(load_take && last), .word_sel(word_sel), .lane(lane),
    .byte_in(bus_rdata), .half(half), .sign_ext(attr.sign_ext),
    .res0(rdata0), .res1(rdata1)
  );

  ubs_store_sel u_store (
    .clk(clk), .rst_n(rst_n), .load_en(accept), .wdata0(req_wdata0),
    .wdata1(req_wdata1), .write(attr.write), .word_sel(word_sel),
    .lane(lane), .byte_out(bus_wdata)
  );

  assign bus_req    = (state == ST_XFER);
  assign bus_addr   = base + ADDR_W'(idx);
  assign bus_write  = attr.write;
  assign bus_unpriv = attr.unpriv;

  assign busy  = (state != ST_IDLE);
  assign done  = (state == ST_FIN) && !err_seen;
  assign fault = (state == ST_FIN) && err_seen;
endmodule

// File: rtl/ubs_chk.sv
module ubs_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              done,
  input logic              fault,
  input logic              bus_req,
  input logic              bus_ready,
  input logic              bus_err,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_write,
  input logic [7:0]        bus_wdata,
  input logic              bus_unpriv
);
  // R2
  addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && $past(bus_req && bus_ready && !bus_err)) |-> (bus_addr == $past(bus_addr) + 1'b1));

  // R8
  err_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_ready && bus_err) |=> (!bus_req && fault && !done));

  // R9
  pulse_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done || fault) |-> (busy && !(done && fault)));

  // R9
  busy_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done || fault) |=> !busy);

  // R10
  unpriv_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && $past(bus_req)) |-> $stable(bus_unpriv));

  // R11
  wait_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_ready) |=> (bus_req && $stable(bus_addr) && $stable(bus_write) && $stable(bus_wdata)));
endmodule

bind unaligned_byte_seq ubs_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .fault(fault),
  .bus_req(bus_req), .bus_ready(bus_ready), .bus_err(bus_err),
  .bus_addr(bus_addr), .bus_write(bus_write), .bus_wdata(bus_wdata),
  .bus_unpriv(bus_unpriv)
);

// File: tb/unaligned_byte_seq_test.sv
`timescale 1ns/1ps
module unaligned_byte_seq_test;
  localparam int AW = 12;

  logic clk = 1'b0;
  logic rst_n;
  logic req_valid, req_write, req_big_endian, req_sign_ext, req_unpriv;
  logic [AW-1:0] req_addr;
  logic [1:0] req_size;
  logic [31:0] req_wdata0, req_wdata1;
  logic busy, done, fault, bus_req, bus_write, bus_unpriv, bus_ready, bus_err;
  logic [31:0] rdata0, rdata1;
  logic [AW-1:0] bus_addr;
  logic [7:0] bus_wdata, bus_rdata;

  always #2.5 clk = ~clk;

  unaligned_byte_seq #(.ADDR_W(AW)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_size(req_size), .req_write(req_write), .req_wdata0(req_wdata0),
    .req_wdata1(req_wdata1), .req_big_endian(req_big_endian),
    .req_sign_ext(req_sign_ext), .req_unpriv(req_unpriv), .busy(busy),
    .done(done), .fault(fault), .rdata0(rdata0), .rdata1(rdata1),
    .bus_req(bus_req), .bus_addr(bus_addr), .bus_write(bus_write),
    .bus_wdata(bus_wdata), .bus_unpriv(bus_unpriv), .bus_ready(bus_ready),
    .bus_rdata(bus_rdata), .bus_err(bus_err)
  );

  // bus model: 64-byte memory, optional wait states and error address
  logic [7:0] mem [0:63];
  logic [AW-1:0] log_a [0:63];
  int log_n, up_bad;
  bit exp_up, slow, err_en;
  logic [5:0] err_addr;
  logic [1:0] wcnt;

  always_comb bus_ready = bus_req && (!slow || wcnt == 2'd2);
  always_comb bus_rdata = mem[bus_addr[5:0]];
  always_comb bus_err   = err_en && (bus_addr[5:0] == err_addr);

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 64; i++) mem[i] <= 8'(i * 37 + 5);
      log_n <= 0; up_bad <= 0; wcnt <= 2'd0;
    end else begin
      if (bus_req && !bus_ready) wcnt <= wcnt + 2'd1;
      else wcnt <= 2'd0;
      if (bus_req && bus_ready) begin
        log_a[log_n % 64] <= bus_addr;
        log_n <= log_n + 1;
        if (bus_unpriv !== exp_up) up_bad <= up_bad + 1;
        if (bus_write && !bus_err) mem[bus_addr[5:0]] <= bus_wdata;
      end
    end
  end

  int n_tests = 0, n_fail = 0;
  bit got_done, got_fault;
  int log0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] mb(input int a);
    return mem[a & 63];
  endfunction

  function automatic logic [31:0] word_at(input int a, input bit be);
    return be ? {mb(a), mb(a+1), mb(a+2), mb(a+3)} : {mb(a+3), mb(a+2), mb(a+1), mb(a)};
  endfunction

  task automatic issue(input int a, input logic [1:0] sz, input bit wr,
                       input logic [31:0] w0, input logic [31:0] w1,
                       input bit be, input bit sx, input bit up);
    @(negedge clk);
    req_addr = AW'(a); req_size = sz; req_write = wr; req_wdata0 = w0;
    req_wdata1 = w1; req_big_endian = be; req_sign_ext = sx; req_unpriv = up;
    exp_up = up; log0 = log_n; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    check(busy === 1'b1, "R9", "busy after accept", 32'(busy), 32'd1);
  endtask

  task automatic finish_wait;
    got_done = 0; got_fault = 0;
    for (int i = 0; i < 200; i++) begin
      if (done || fault) begin
        got_done = done; got_fault = fault;
        check(busy === 1'b1, "R9", "busy during pulse", 32'(busy), 32'd1);
        break;
      end
      @(negedge clk);
    end
    @(negedge clk);
    check(busy === 1'b0, "R9", "busy after pulse", 32'(busy), 32'd0);
  endtask

  task automatic run(input int a, input logic [1:0] sz, input bit wr,
                     input logic [31:0] w0, input logic [31:0] w1,
                     input bit be, input bit sx, input bit up);
    issue(a, sz, wr, w0, w1, be, sx, up);
    finish_wait();
  endtask

  task automatic check_seq(input string req, input int a, input int n);
    check(log_n - log0 == n, req, "byte count", 32'(log_n - log0), 32'(n));
    for (int k = 0; k < n; k++)
      check(log_a[(log0 + k) % 64] == AW'(a + k), req, "byte address",
            32'(log_a[(log0 + k) % 64]), 32'(AW'(a + k)));
  endtask

  task automatic t_reset;
    check({busy, done, fault, bus_req} === 4'b0, "R1", "flags after reset",
          32'({busy, done, fault, bus_req}), 32'd0);
    check(rdata0 === 32'd0 && rdata1 === 32'd0, "R1", "results after reset", rdata0 | rdata1, 32'd0);
  endtask

  task automatic t_le_word;
    logic [31:0] e;
    e = word_at(5, 0);
    run(5, 2'b01, 0, 0, 0, 0, 0, 0);
    check(got_done && !got_fault, "R3", "done status", 32'({got_done, got_fault}), 32'd2);
    check(rdata0 === e, "R3", "LE word at 5", rdata0, e);
    check(rdata1 === 32'd0, "R5", "rdata1 zero for word", rdata1, 32'd0);
    check_seq("R2", 5, 4);
    e = word_at(7, 0);
    run(7, 2'b11, 0, 0, 0, 0, 1, 0);
    check(rdata0 === e, "R5", "sign flag no effect on word", rdata0, e);
    check_seq("R2", 7, 4);
  endtask

  task automatic t_be_loads;
    logic [31:0] e;
    e = word_at(6, 1);
    run(6, 2'b01, 0, 0, 0, 1, 0, 1);
    check(rdata0 === e, "R4", "BE word at 6", rdata0, e);
    e = {16'h0, mb(4), mb(5)};
    run(4, 2'b00, 0, 0, 0, 1, 0, 0);
    check(rdata0 === e, "R4", "BE half at 4", rdata0, e);
    check_seq("R2", 4, 2);
  endtask

  task automatic t_half_sign;
    logic [31:0] e;
    e = {16'hFFFF, mb(4), mb(3)};
    run(3, 2'b00, 0, 0, 0, 0, 1, 0);
    check(rdata0 === e, "R5", "LE half signed negative", rdata0, e);
    e = {16'h0000, mb(4), mb(3)};
    run(3, 2'b00, 0, 0, 0, 0, 0, 0);
    check(rdata0 === e, "R5", "LE half zero-extended", rdata0, e);
    e = {16'h0000, mb(1), mb(0)};
    run(0, 2'b00, 0, 0, 0, 0, 1, 0);
    check(rdata0 === e, "R5", "LE half signed positive", rdata0, e);
    e = {16'hFFFF, mb(4), mb(5)};
    run(4, 2'b00, 0, 0, 0, 1, 1, 0);
    check(rdata0 === e, "R5", "BE half signed", rdata0, e);
  endtask

  task automatic t_dword_load;
    logic [31:0] e0, e1;
    e0 = word_at(9, 0); e1 = word_at(13, 0);
    run(9, 2'b10, 0, 0, 0, 0, 0, 1);
    check(rdata0 === e0, "R7", "dword first word", rdata0, e0);
    check(rdata1 === e1, "R7", "dword second word", rdata1, e1);
    check_seq("R2", 9, 8);
  endtask

  task automatic t_stores;
    run(40, 2'b01, 1, 32'hA1B2C3D4, 0, 1, 0, 0);
    check(word_at(40, 0) === 32'hD4C3B2A1, "R6", "BE store bytes", word_at(40, 0), 32'hD4C3B2A1);
    check(log_a[log0 % 64] == AW'(40), "R6", "BE store first address", 32'(log_a[log0 % 64]), 32'd40);
    run(44, 2'b01, 1, 32'hA1B2C3D4, 0, 0, 0, 1);
    check(word_at(44, 0) === 32'hA1B2C3D4, "R6", "LE store bytes", word_at(44, 0), 32'hA1B2C3D4);
    run(48, 2'b00, 1, 32'h00005A6B, 0, 1, 0, 0);
    check({mb(48), mb(49)} === 16'h5A6B, "R6", "BE half store", 32'({mb(48), mb(49)}), 32'h5A6B);
    check(mb(50) === 8'(50 * 37 + 5), "R6", "byte past half untouched", 32'(mb(50)), 32'(8'(50 * 37 + 5)));
    run(52, 2'b10, 1, 32'h01020304, 32'h05060708, 1, 0, 0);
    check(word_at(52, 1) === 32'h01020304, "R7", "dword store first", word_at(52, 1), 32'h01020304);
    check(word_at(56, 1) === 32'h05060708, "R7", "dword store second", word_at(56, 1), 32'h05060708);
  endtask

  task automatic t_errors;
    logic [31:0] prev, b25;
    prev = rdata0;
    err_en = 1; err_addr = 6'd32;
    run(30, 2'b01, 0, 0, 0, 0, 0, 0);
    check(got_fault && !got_done, "R8", "fault status", 32'({got_done, got_fault}), 32'd1);
    check(rdata0 === prev, "R8", "result kept on fault", rdata0, prev);
    check(log_n - log0 == 3, "R8", "bytes issued before stop", 32'(log_n - log0), 32'd3);
    b25 = 32'(mb(25));
    err_addr = 6'd25;
    run(24, 2'b01, 1, 32'h11223344, 0, 0, 0, 0);
    check(got_fault, "R8", "store fault", 32'(got_fault), 32'd1);
    check(32'(mb(24)) === 32'h44 && 32'(mb(25)) === b25, "R8", "store bytes around error",
          {16'h0, mb(24), mb(25)}, {16'h0, 8'h44, b25[7:0]});
    check(log_n - log0 == 2, "R8", "store stops at error", 32'(log_n - log0), 32'd2);
    err_en = 0;
  endtask

  task automatic t_busy_ignore;
    logic [31:0] e;
    int n;
    e = word_at(8, 0);
    issue(8, 2'b01, 0, 0, 0, 0, 0, 0);
    req_addr = AW'(20); req_valid = 1'b1;
    @(negedge clk); @(negedge clk);
    req_valid = 1'b0;
    finish_wait();
    check(rdata0 === e, "R9", "result of first request", rdata0, e);
    check_seq("R9", 8, 4);
    n = log_n;
    repeat (4) @(negedge clk);
    check(log_n == n && !busy, "R9", "request during busy dropped", 32'(log_n - n), 32'd0);
  endtask

  task automatic t_wait;
    logic [31:0] e;
    slow = 1;
    e = word_at(17, 1);
    run(17, 2'b01, 0, 0, 0, 1, 0, 1);
    check(rdata0 === e, "R11", "load with wait states", rdata0, e);
    check_seq("R11", 17, 4);
    run(60, 2'b00, 1, 32'h0000C3E7, 0, 0, 0, 0);
    check({mb(61), mb(60)} === 16'hC3E7, "R11", "store with wait states",
          32'({mb(61), mb(60)}), 32'hC3E7);
    slow = 0;
  endtask

  task automatic t_wrap;
    logic [31:0] e;
    e = {mb(1), mb(0), mb(63), mb(62)};
    run(12'hFFE, 2'b01, 0, 0, 0, 0, 0, 0);
    check(rdata0 === e, "R12", "wrapped word", rdata0, e);
    check_seq("R12", 12'hFFE, 4);
  endtask

  bit wd_hit = 0;
  initial begin
    repeat (150000) @(posedge clk);
    wd_hit = 1;
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    rst_n = 0; req_valid = 0; req_addr = '0; req_size = 0; req_write = 0;
    req_wdata0 = 0; req_wdata1 = 0; req_big_endian = 0; req_sign_ext = 0;
    req_unpriv = 0; exp_up = 0; slow = 0; err_en = 0; err_addr = 0;
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_le_word();
    t_be_loads();
    t_half_sign();
    t_dword_load();
    t_stores();
    t_errors();
    t_busy_ignore();
    t_wait();
    t_wrap();
    check(up_bad == 0, "R10", "unprivileged attribute mismatches", 32'(up_bad), 32'd0);
    if (!wd_hit) begin
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule